// File: doc/BRIEF.md
# Serial Character Receiver with Per-Character Status

This block receives asynchronous serial characters and queues them for a reader. A start bit is detected and confirmed at its middle using a 16x oversampling tick. The data bits arrive least significant bit first and are assembled into a character. Each character is checked for parity and for a valid stop bit. It then goes into a four-entry queue, and its two error flags go into the same entry. The reader sees the character at the head of the queue together with that character's own error flags, and removes it with a one-cycle read strobe.

Characters can be 8 bits with no, even or odd parity, or 9 bits with no parity. In 9-bit mode an address filter can be enabled for multidrop links. When it is on, only characters whose ninth bit is set are kept. A character that completes while the queue is full raises a sticky overrun flag. Software clears that flag with a strobe, and the clear also empties the queue and abandons any frame in progress. The serial input passes through a two-stage synchronizer. The reset input is asserted asynchronously and its release is synchronized inside the block.

Top module: `uart_rx_status`

## Requirements
- R1: After reset `rx_idle` is 1, `rx_avail` is 0 and `overrun` is 0.
- R2: A frame is a low start bit, then 8 data bits (or 9 when `cfg_nine_bit`=1) sent least significant bit first, then an optional parity bit, then a stop bit. Each bit lasts 16 `baud_tick` pulses. The head character appears on `rx_data[8:0]`, and bit 8 is 0 for 8-bit characters.
- R3: A start bit that reads high at its middle (the 8th tick after the falling edge is seen) is discarded as a glitch. No character is stored, and the receiver goes back to idle.
- R4: `cfg_parity` selects 2'b00 none, 2'b01 even, 2'b10 odd (2'b11 behaves as none). A parity bit follows the data only in 8-bit mode with even or odd selected. `par_err` is 1 when the received parity does not match. In 9-bit mode no parity bit is expected and `par_err` stays 0.
- R5: `frm_err` is 1 when the character's stop bit was sampled low. That character is still stored.
- R6: `par_err` and `frm_err` describe the head character, not the newest one.
- R7: `rx_avail` is 1 exactly when the queue holds at least one character. `rd_stb` removes the head character, and `rd_stb` on an empty queue has no effect.
- R8: A kept character that completes while 4 characters are stored sets `overrun` and is dropped. While `overrun` is 1, every further completed character is dropped and the stored characters are kept.
- R9: `ovr_clr` while `overrun`=1 clears `overrun`, empties the queue and returns the receiver to idle. `ovr_clr` while `overrun`=0 has no effect.
- R10: With `cfg_nine_bit`=1 and `cfg_addr_det`=1, only characters whose bit 8 is 1 are stored.
- R11: With `cfg_nine_bit`=0, `cfg_addr_det` has no effect and every character is stored.
- R12: `rx_idle` is 0 from the detection of a start bit until the frame ends or is rejected, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_stb | input | 1 | Removes the head character |
| cfg_nine_bit | input | 1 | 1 selects 9-bit characters |
| cfg_addr_det | input | 1 | Address filter enable (only in 9-bit mode) |
| cfg_parity | input | 2 | Parity mode: 00 none, 01 even, 10 odd |
| ovr_clr | input | 1 | Clears the overrun flag and flushes the receive path |
| rx_data | output | 9 | Head character |
| rx_avail | output | 1 | Queue not empty |
| rx_idle | output | 1 | No frame in progress |
| par_err | output | 1 | Parity error of the head character |
| frm_err | output | 1 | Framing error of the head character |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong oversampling count or a wrong bit index shows up quickly. The stored character differs, and `rx_data` shows it one cycle after the stop bit's middle. The same fault can also move the moment `rx_idle` rises, which shows on the very next clock. A fault in the queue or in the overrun logic shows as a wrong `rx_avail`, a wrong head value or a flag that stays set, but only when a read or a fifth character touches that state. For this reason the bench compares every output against a behavioural model on every clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10
  } par_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_entry_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  // line idles high, so the chain resets to ones
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rx_deser.sv
module rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tick,
  input  logic              rxs,
  input  logic              nine_bit,
  input  logic [1:0]        par_mode,
  output logic              idle_o,
  output logic              done_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam int IW = $clog2(CHAR_W + 1);

  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              pe_q, pe_d;
  logic              fe_q, fe_d;
  logic              done_q, done_d;

  logic              par_on;
  logic              par_odd;
  logic [IW-1:0]     last_idx;

  assign par_on   = !nine_bit && (par_mode == PAR_EVEN || par_mode == PAR_ODD);
  assign par_odd  = (par_mode == PAR_ODD);
  assign last_idx = nine_bit ? IW'(CHAR_W - 1) : IW'(CHAR_W - 2);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    done_d = 1'b0;
    if (flush) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rxs) begin
            st_d  = RX_START;
            cnt_d = '0;
            sh_d  = '0;
            pe_d  = 1'b0;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            if (!rxs) begin
              st_d  = RX_DATA;
              cnt_d = '0;
              idx_d = '0;
            end else begin
              st_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d       = '0;
            sh_d[idx_q] = rxs;
            if (idx_q == last_idx) st_d = par_on ? RX_PAR : RX_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            pe_d  = ((^sh_q[CHAR_W-2:0]) ^ rxs) != par_odd;
            st_d  = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            done_d = 1'b1;
            fe_d   = !rxs;
            st_d   = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      done_q <= done_d;
    end
  end

  assign idle_o = (st_q == RX_IDLE);
  assign done_o = done_q;
  assign data_o = sh_q;
  assign perr_o = pe_q;
  assign ferr_o = fe_q;

  // R12
  idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_o) |-> $past(tick && !rxs));

  // R2
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == RX_STOP));

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t wdata,
  input  logic      pop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= wdata;
  end

  assign head = mem_q[rd_q];

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       rd_stb,
  input  logic       cfg_nine_bit,
  input  logic       cfg_addr_det,
  input  logic [1:0] cfg_parity,
  input  logic       ovr_clr,
  output logic [8:0] rx_data,
  output logic       rx_avail,
  output logic       rx_idle,
  output logic       par_err,
  output logic       frm_err,
  output logic       overrun
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic              rxs;
  logic              flush;
  logic              d_idle, d_done, d_perr, d_ferr;
  logic [CHAR_W-1:0] d_data;
  logic              accept, push, pop;
  logic              f_empty, f_full;
  rx_entry_t         wentry, hentry;
  logic              ovr_q, ovr_d;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (rxd),
    .dout  (rxs)
  );

  rx_deser #(.OVS(OVS)) u_deser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flush    (flush),
    .tick     (baud_tick),
    .rxs      (rxs),
    .nine_bit (cfg_nine_bit),
    .par_mode (cfg_parity),
    .idle_o   (d_idle),
    .done_o   (d_done),
    .data_o   (d_data),
    .perr_o   (d_perr),
    .ferr_o   (d_ferr)
  );

  assign flush  = ovr_clr && ovr_q;
  assign accept = d_done && !(cfg_nine_bit && cfg_addr_det && !d_data[CHAR_W-1]);
  assign push   = accept && !f_full && !ovr_q && !flush;
  assign pop    = rd_stb && !f_empty;

  assign wentry.data = d_data;
  assign wentry.perr = d_perr;
  assign wentry.ferr = d_ferr;

  rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .flush (flush),
    .push  (push),
    .wdata (wentry),
    .pop   (pop),
    .head  (hentry),
    .empty (f_empty),
    .full  (f_full)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (flush)                           ovr_d = 1'b0;
    else if (accept && f_full && !ovr_q) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ovr_q <= 1'b0;
    else            ovr_q <= ovr_d;
  end

  assign rx_data  = hentry.data;
  assign par_err  = hentry.perr;
  assign frm_err  = hentry.ferr;
  assign rx_avail = !f_empty;
  assign rx_idle  = d_idle;
  assign overrun  = ovr_q;

  // R8
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (overrun && !ovr_clr) |=> overrun);

  // R8
  keep_contents_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (overrun && !rd_stb && !ovr_clr) |=> ($stable(rx_avail) && $stable(rx_data)));

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ovr_clr && overrun) |=> (!rx_avail && rx_idle && !overrun));

  // R10
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (push && cfg_nine_bit && cfg_addr_det) |-> d_data[CHAR_W-1]);

endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rd_stb = 1'b0;
  logic       cfg_nine_bit = 1'b0;
  logic       cfg_addr_det = 1'b0;
  logic [1:0] cfg_parity = 2'b00;
  logic       ovr_clr = 1'b0;
  logic [8:0] rx_data;
  logic       rx_avail, rx_idle, par_err, frm_err, overrun;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit finished = 1'b0;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .rd_stb(rd_stb), .cfg_nine_bit(cfg_nine_bit), .cfg_addr_det(cfg_addr_det),
    .cfg_parity(cfg_parity), .ovr_clr(ovr_clr), .rx_data(rx_data),
    .rx_avail(rx_avail), .rx_idle(rx_idle), .par_err(par_err),
    .frm_err(frm_err), .overrun(overrun)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    baud_tick = cyc[0];
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [10:0] q[$];
  bit          m_ovr, m_s1, m_s2, m_pe, m_fe, m_done;
  int          m_st, m_cnt, m_idx;
  logic [8:0]  m_sh;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovr = 0; m_s1 = 1; m_s2 = 1; m_pe = 0; m_fe = 0;
      m_done = 0; m_st = 0; m_cnt = 0; m_idx = 0; m_sh = '0;
    end else begin
      bit fl, acc, was_full;
      fl = ovr_clr && m_ovr;
      if (fl) begin
        q.delete(); m_ovr = 0;
      end else begin
        acc = m_done && !(cfg_nine_bit && cfg_addr_det && !m_sh[8]);
        was_full = (q.size() == 4);
        if (rd_stb && q.size() > 0) void'(q.pop_front());
        if (acc && !m_ovr) begin
          if (was_full) m_ovr = 1;
          else q.push_back({m_sh, m_pe, m_fe});
        end
      end
      m_done = 0;
      if (fl) begin
        m_st = 0; m_cnt = 0;
      end else if (baud_tick) begin
        case (m_st)
          0: if (!m_s2) begin m_st = 1; m_cnt = 0; m_sh = '0; m_pe = 0; end
          1: if (m_cnt == 7) begin
               if (!m_s2) begin m_st = 2; m_cnt = 0; m_idx = 0; end else m_st = 0;
             end else m_cnt++;
          2: if (m_cnt == 15) begin
               m_cnt = 0; m_sh[m_idx] = m_s2;
               if (m_idx == (cfg_nine_bit ? 8 : 7))
                 m_st = (!cfg_nine_bit && (cfg_parity == 2'b01 || cfg_parity == 2'b10)) ? 3 : 4;
               else m_idx++;
             end else m_cnt++;
          3: if (m_cnt == 15) begin
               m_cnt = 0; m_pe = ((^m_sh[7:0]) ^ m_s2) != (cfg_parity == 2'b10); m_st = 4;
             end else m_cnt++;
          4: if (m_cnt == 15) begin m_done = 1; m_fe = !m_s2; m_st = 0; end
             else m_cnt++;
          default: m_st = 0;
        endcase
      end
      m_s2 = m_s1; m_s1 = rxd;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R12 rx_idle", {15'd0, rx_idle}, {15'd0, (m_st == 0)});
      chk("R7 rx_avail", {15'd0, rx_avail}, {15'd0, (q.size() > 0)});
      chk("R8 overrun", {15'd0, overrun}, {15'd0, m_ovr});
      if (q.size() > 0) begin
        chk("R2 rx_data", {7'd0, rx_data}, {7'd0, q[0][10:2]});
        chk("R6 par_err", {15'd0, par_err}, {15'd0, q[0][1]});
        chk("R5 frm_err", {15'd0, frm_err}, {15'd0, q[0][0]});
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input bit use_p,
                      input bit p, input bit bad_stop);
    rxd = 1'b0; wclk(32);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wclk(32); end
    if (use_p) begin rxd = p; wclk(32); end
    if (bad_stop) begin rxd = 1'b0; wclk(24); end
    rxd = 1'b1; wclk(40);
  endtask

  task automatic rd();
    rd_stb = 1'b1; wclk(1); rd_stb = 1'b0; wclk(1);
  endtask

  task automatic oclr();
    ovr_clr = 1'b1; wclk(1); ovr_clr = 1'b0; wclk(1);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
  endtask

  initial begin
    wclk(4); rst_n = 1'b1; wclk(6);
    // R1 reset state
    chk("R1 idle", {15'd0, rx_idle}, 16'd1);
    chk("R1 avail", {15'd0, rx_avail}, 16'd0);
    chk("R1 overrun", {15'd0, overrun}, 16'd0);

    // R2 8-bit, no parity
    send(9'h0A5, 8, 0, 0, 0);
    chk("R2 avail", {15'd0, rx_avail}, 16'd1);
    chk("R2 data", {7'd0, rx_data}, 16'h00A5);
    rd();
    chk("R7 empty after read", {15'd0, rx_avail}, 16'd0);
    rd();
    chk("R7 read on empty", {15'd0, rx_avail}, 16'd0);

    // R4 even parity, R6 head reporting
    cfg_parity = 2'b01;
    send(9'h03C, 8, 1, 0, 0);
    send(9'h03C, 8, 1, 1, 0);
    chk("R6 head perr good", {15'd0, par_err}, 16'd0);
    rd();
    chk("R4 even perr bad", {15'd0, par_err}, 16'd1);
    rd();

    // R4 odd parity
    cfg_parity = 2'b10;
    send(9'h001, 8, 1, 0, 0);
    chk("R4 odd good", {15'd0, par_err}, 16'd0);
    rd();
    send(9'h001, 8, 1, 1, 0);
    chk("R4 odd bad", {15'd0, par_err}, 16'd1);
    rd();

    // R5 framing error
    cfg_parity = 2'b00;
    send(9'h055, 8, 0, 0, 1);
    chk("R5 avail", {15'd0, rx_avail}, 16'd1);
    chk("R5 ferr", {15'd0, frm_err}, 16'd1);
    chk("R5 data", {7'd0, rx_data}, 16'h0055);
    rd();

    // R3 glitch start, R12 busy during start
    rxd = 1'b0; wclk(6); rxd = 1'b1; wclk(2);
    chk("R12 busy", {15'd0, rx_idle}, 16'd0);
    wclk(40);
    chk("R3 back to idle", {15'd0, rx_idle}, 16'd1);
    chk("R3 nothing stored", {15'd0, rx_avail}, 16'd0);

    // R10 address filter in 9-bit mode, R4 no parity in 9-bit mode
    cfg_nine_bit = 1'b1; cfg_addr_det = 1'b1; cfg_parity = 2'b01;
    send(9'h0AA, 9, 0, 0, 0);
    chk("R10 data char dropped", {15'd0, rx_avail}, 16'd0);
    send(9'h1AA, 9, 0, 0, 0);
    chk("R10 address kept", {7'd0, rx_data}, 16'h01AA);
    chk("R4 nine-bit perr", {15'd0, par_err}, 16'd0);
    rd();

    // R11 filter ignored in 8-bit mode
    cfg_nine_bit = 1'b0; cfg_parity = 2'b00;
    send(9'h012, 8, 0, 0, 0);
    chk("R11 kept", {7'd0, rx_data}, 16'h0012);
    rd();
    cfg_addr_det = 1'b0;

    // R9 clear without overrun does nothing
    send(9'h077, 8, 0, 0, 0);
    oclr();
    chk("R9 no-op avail", {15'd0, rx_avail}, 16'd1);
    chk("R9 no-op data", {7'd0, rx_data}, 16'h0077);
    rd();

    // R8 overrun
    for (int k = 1; k <= 4; k++) send(9'(k), 8, 0, 0, 0);
    chk("R8 four stored no overrun", {15'd0, overrun}, 16'd0);
    send(9'h005, 8, 0, 0, 0);
    chk("R8 overrun set", {15'd0, overrun}, 16'd1);
    chk("R8 head kept", {7'd0, rx_data}, 16'h0001);
    rd();
    send(9'h006, 8, 0, 0, 0);
    chk("R8 head 2", {7'd0, rx_data}, 16'h0002);
    rd();
    chk("R8 head 3", {7'd0, rx_data}, 16'h0003);
    rd();
    chk("R8 head 4", {7'd0, rx_data}, 16'h0004);
    rd();
    chk("R8 later chars dropped", {15'd0, rx_avail}, 16'd0);
    chk("R8 still set", {15'd0, overrun}, 16'd1);
    oclr();
    chk("R9 cleared", {15'd0, overrun}, 16'd0);

    // R9 flush with full queue and a frame in progress
    for (int k = 0; k < 5; k++) send(9'(8'h11 + k), 8, 0, 0, 0);
    chk("R8 overrun again", {15'd0, overrun}, 16'd1);
    rxd = 1'b0; wclk(32); rxd = 1'b1; wclk(16);
    chk("R12 busy mid frame", {15'd0, rx_idle}, 16'd0);
    oclr();
    chk("R9 idle after flush", {15'd0, rx_idle}, 16'd1);
    chk("R9 queue empty", {15'd0, rx_avail}, 16'd0);
    chk("R9 flag clear", {15'd0, overrun}, 16'd0);
    wclk(100);
    chk("R9 partial frame gone", {15'd0, rx_avail}, 16'd0);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog expired (all requirements) got running expected done");
      report();
      $finish;
    end
  end

endmodule